// File: doc/BRIEF.md
# NAND Flash Page Read Controller

This host-side controller runs page reads on an asynchronous 8-bit NAND flash bus. A request supplies a 24-bit page (row) address, a 12-bit start column and a byte count. The controller drives chip enable, the command and address latch strobes, the write strobe and the 8-bit I/O bus to send the read sequence. It then watches the ready/busy line until the array-to-register transfer is done. After that it pulses the read strobe once per byte and passes each byte to a valid/ready output stream.

When a page is already in the device's data register, a request marked as a jump sends a short column-change sequence. The read pointer moves to a new column inside that page and the array is not read again. When consecutive page reads follow a successful one, the leading read command is left out. A timeout ends the busy wait if ready/busy stays low for too long. All strobe widths and waits are counted in clock cycles and set by parameters.

Top module: `nand_page_reader`

## Requirements
- R1: After reset, chip enable, write strobe and read strobe are high. Both latch strobes and `nand_io_oe_o` are low, `dout_valid_o` and `err_timeout_o` are low, and `req_ready_o` is high.
- R2: With no page loaded, a full read sends seven bytes, each latched on a rising edge of the write strobe. Command 0x00 goes out with CLE high. Five address bytes follow with ALE high: column bits 7:0, then {4'h0, column bits 11:8}, then row bits 7:0, 15:8 and 23:16. Command 0x30 closes the sequence with CLE high.
- R3: When a previous full read completed without timeout, a new full read leaves out the leading 0x00 and sends only the five address bytes and 0x30.
- R4: After 0x30 the controller waits WB_CYC cycles, then waits for the synchronized ready/busy line to be high. No read strobe pulse happens while ready/busy is low.
- R5: The controller outputs min(len, 2112 - column) bytes, or zero bytes if the column is 2112 or more. There is one read strobe pulse per byte, and the bytes come in ascending column order from the start column. `dout_last_o` is high only with the final byte. A count of zero gives no read strobe pulse.
- R6: While `dout_valid_o` is high and `dout_ready_i` is low, `dout_data_o` holds its value and the read strobe stays high.
- R7: A jump request when a page is loaded sends command 0x05, the two column bytes (same layout as in R2), then command 0xE0. It waits WHR_CYC cycles with no busy wait and reads from the new column of the same page. A jump request with no page loaded is carried out as a full read.
- R8: If ready/busy stays low for TIMEOUT_CYC cycles of the busy wait, `err_timeout_o` goes high and the controller returns to idle without a read strobe pulse. The page then counts as not loaded. The flag clears when the next request is accepted.
- R9: Each write strobe low phase lasts WE_LO_CYC cycles and each read strobe low phase lasts RE_LO_CYC cycles. Chip enable stays low for the whole operation.
- R10: `req_ready_o` is high only while the bus is idle (chip enable high). Write and read strobes are never low together, and CLE and ALE are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_jump_i | input | 1 | 1: column jump inside the loaded page |
| req_row_i | input | 24 | Page (row) address |
| req_col_i | input | 12 | Start column |
| req_len_i | input | 12 | Requested byte count |
| dout_valid_o | output | 1 | Read byte valid |
| dout_ready_i | input | 1 | Consumer ready |
| dout_data_o | output | 8 | Read byte |
| dout_last_o | output | 1 | Final byte of the request |
| err_timeout_o | output | 1 | Busy wait timed out |
| nand_ce_no | output | 1 | Chip enable, active low |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_no | output | 1 | Write strobe, active low |
| nand_re_no | output | 1 | Read strobe, active low |
| nand_io_o | output | 8 | I/O bus out |
| nand_io_oe_o | output | 1 | I/O bus output enable |
| nand_io_i | input | 8 | I/O bus in |
| nand_rb_i | input | 1 | Ready/busy, low while busy |

## Verification
The assertions check four things on every cycle: the strobe and latch-enable exclusions, the exact low widths of both strobes, the absence of any read pulse while ready/busy is low, and the output hold under backpressure. They also check that a timeout always lands in idle. Other behaviours need scenarios that a device model observes. These are the byte order of the command and address sequences, leaving out 0x00 on back-to-back reads, choosing between jump and full read from whether a page is loaded, the byte count clipped at the page end, and the data values for each column.

// File: rtl/nand_rd_pkg.sv
package nand_rd_pkg;
  localparam int COL_W = 12;
  localparam int ROW_W = 24;

  localparam logic [7:0] CMD_RD_SETUP = 8'h00;
  localparam logic [7:0] CMD_RD_GO    = 8'h30;
  localparam logic [7:0] CMD_JMP_SET  = 8'h05;
  localparam logic [7:0] CMD_JMP_GO   = 8'hE0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WE_LO, ST_WE_HI, ST_WAIT_WB, ST_WAIT_RB, ST_WAIT_WHR, ST_RE_LO, ST_RE_HI
  } rd_state_e;

  typedef struct packed {
    logic [7:0] data;
    logic       cle;
    logic       ale;
    logic       last;
  } bus_beat_t;
endpackage

// File: rtl/nand_cycle_timer.sv
module nand_cycle_timer #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/nand_rb_watch.sv
module nand_rb_watch #(
  parameter int TIMEOUT_CYC = 2500,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rb_i,
  input  logic arm_i,
  output logic ready_o,
  output logic timeout_o
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic                   rb_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], rb_i};
  end
  assign rb_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!arm_i)        cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign ready_o   = arm_i & rb_s;
  assign timeout_o = arm_i & ~rb_s & (cnt_q == LIMIT);
endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nand_rd_pkg::*;
(
  input  logic             jump_i,
  input  logic [2:0]       step_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [ROW_W-1:0] row_i,
  output bus_beat_t        beat_o
);
  logic [7:0] col_lo, col_hi;
  assign col_lo = col_i[7:0];
  assign col_hi = {4'h0, col_i[11:8]};

  always_comb begin
    beat_o = '0;
    if (jump_i) begin
      unique case (step_i)
        3'd0:    beat_o = '{data: CMD_JMP_SET, cle: 1'b1, ale: 1'b0, last: 1'b0};
        3'd1:    beat_o = '{data: col_lo,      cle: 1'b0, ale: 1'b1, last: 1'b0};
        3'd2:    beat_o = '{data: col_hi,      cle: 1'b0, ale: 1'b1, last: 1'b0};
        default: beat_o = '{data: CMD_JMP_GO,  cle: 1'b1, ale: 1'b0, last: 1'b1};
      endcase
    end else begin
      unique case (step_i)
        3'd0:    beat_o = '{data: CMD_RD_SETUP,  cle: 1'b1, ale: 1'b0, last: 1'b0};
        3'd1:    beat_o = '{data: col_lo,        cle: 1'b0, ale: 1'b1, last: 1'b0};
        3'd2:    beat_o = '{data: col_hi,        cle: 1'b0, ale: 1'b1, last: 1'b0};
        3'd3:    beat_o = '{data: row_i[7:0],    cle: 1'b0, ale: 1'b1, last: 1'b0};
        3'd4:    beat_o = '{data: row_i[15:8],   cle: 1'b0, ale: 1'b1, last: 1'b0};
        3'd5:    beat_o = '{data: row_i[23:16],  cle: 1'b0, ale: 1'b1, last: 1'b0};
        default: beat_o = '{data: CMD_RD_GO,     cle: 1'b1, ale: 1'b0, last: 1'b1};
      endcase
    end
  end
endmodule

// File: rtl/nand_page_reader.sv
module nand_page_reader
  import nand_rd_pkg::*;
#(
  parameter int PAGE_BYTES  = 2112,
  parameter int WE_LO_CYC   = 2,
  parameter int WE_HI_CYC   = 1,
  parameter int RE_LO_CYC   = 2,
  parameter int RE_HI_CYC   = 1,
  parameter int WB_CYC      = 8,
  parameter int WHR_CYC     = 6,
  parameter int TIMEOUT_CYC = 2500,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_jump_i,
  input  logic [ROW_W-1:0] req_row_i,
  input  logic [COL_W-1:0] req_col_i,
  input  logic [COL_W-1:0] req_len_i,
  output logic             dout_valid_o,
  input  logic             dout_ready_i,
  output logic [7:0]       dout_data_o,
  output logic             dout_last_o,
  output logic             err_timeout_o,
  output logic             nand_ce_no,
  output logic             nand_cle_o,
  output logic             nand_ale_o,
  output logic             nand_we_no,
  output logic             nand_re_no,
  output logic [7:0]       nand_io_o,
  output logic             nand_io_oe_o,
  input  logic [7:0]       nand_io_i,
  input  logic             nand_rb_i
);
  localparam int TW = $clog2(WE_LO_CYC + WE_HI_CYC + RE_LO_CYC + RE_HI_CYC + WB_CYC + WHR_CYC + 1);
  localparam int NW = COL_W + 1;
  localparam logic [TW-1:0] WE_LO_L = TW'(WE_LO_CYC - 1);
  localparam logic [TW-1:0] WE_HI_L = TW'(WE_HI_CYC - 1);
  localparam logic [TW-1:0] RE_LO_L = TW'(RE_LO_CYC - 1);
  localparam logic [TW-1:0] RE_HI_L = TW'(RE_HI_CYC - 1);
  localparam logic [TW-1:0] WB_L    = TW'(WB_CYC - 1);
  localparam logic [TW-1:0] WHR_L   = TW'(WHR_CYC - 1);
  localparam logic [NW-1:0] PAGE_N  = NW'(PAGE_BYTES);

  rd_state_e        state_q, state_d;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             jump_q, loaded_q, err_q;
  logic [2:0]       step_q;
  logic [NW-1:0]    rem_q, rem_calc, avail;
  logic [7:0]       data_q;
  logic             valid_q, last_q;
  logic             tmr_load, tmr_zero, accept, step_inc, sample;
  logic [TW-1:0]    tmr_val;
  logic             rb_ready, rb_timeout, in_wr, take_jump;
  bus_beat_t        beat;

  nand_cycle_timer #(.W(TW)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load), .val_i(tmr_val), .zero_o(tmr_zero)
  );

  nand_rb_watch #(.TIMEOUT_CYC(TIMEOUT_CYC), .SYNC_STAGES(SYNC_STAGES)) u_rb (
    .clk_i(clk_i), .rst_ni(rst_ni), .rb_i(nand_rb_i), .arm_i(state_q == ST_WAIT_RB),
    .ready_o(rb_ready), .timeout_o(rb_timeout)
  );

  nand_cmd_seq u_seq (
    .jump_i(jump_q), .step_i(step_q), .col_i(col_q), .row_i(row_q), .beat_o(beat)
  );

  // byte count clipped to the page end
  assign avail     = ({1'b0, req_col_i} < PAGE_N) ? PAGE_N - {1'b0, req_col_i} : '0;
  assign rem_calc  = ({1'b0, req_len_i} < avail) ? {1'b0, req_len_i} : avail;
  assign take_jump = req_jump_i & loaded_q;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    accept   = 1'b0;
    step_inc = 1'b0;
    sample   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) begin
        accept = 1'b1; tmr_load = 1'b1; tmr_val = WE_LO_L; state_d = ST_WE_LO;
      end
      ST_WE_LO: if (tmr_zero) begin
        tmr_load = 1'b1; tmr_val = WE_HI_L; state_d = ST_WE_HI;
      end
      ST_WE_HI: if (tmr_zero) begin
        tmr_load = 1'b1;
        if (beat.last) begin
          tmr_val = jump_q ? WHR_L : WB_L;
          state_d = jump_q ? ST_WAIT_WHR : ST_WAIT_WB;
        end else begin
          step_inc = 1'b1; tmr_val = WE_LO_L; state_d = ST_WE_LO;
        end
      end
      ST_WAIT_WB:  if (tmr_zero) state_d = ST_WAIT_RB;
      ST_WAIT_RB: begin
        if (rb_ready)        state_d = ST_RE_HI;
        else if (rb_timeout) state_d = ST_IDLE;
      end
      ST_WAIT_WHR: if (tmr_zero) state_d = ST_RE_HI;
      ST_RE_HI: if (tmr_zero) begin
        if (rem_q == '0) state_d = ST_IDLE;
        else if (!valid_q || dout_ready_i) begin
          tmr_load = 1'b1; tmr_val = RE_LO_L; state_d = ST_RE_LO;
        end
      end
      ST_RE_LO: if (tmr_zero) begin
        sample = 1'b1; tmr_load = 1'b1; tmr_val = RE_HI_L; state_d = ST_RE_HI;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      row_q    <= '0;
      col_q    <= '0;
      jump_q   <= 1'b0;
      step_q   <= '0;
      rem_q    <= '0;
      loaded_q <= 1'b0;
      err_q    <= 1'b0;
      data_q   <= '0;
      last_q   <= 1'b0;
      valid_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        row_q  <= req_row_i;
        col_q  <= req_col_i;
        jump_q <= take_jump;
        step_q <= (loaded_q && !take_jump) ? 3'd1 : 3'd0;  // skip 00h when page is loaded
        rem_q  <= rem_calc;
        err_q  <= 1'b0;
      end
      if (step_inc) step_q <= step_q + 3'd1;
      if (state_q == ST_WAIT_RB) begin
        if (rb_ready) loaded_q <= 1'b1;
        else if (rb_timeout) begin
          loaded_q <= 1'b0;
          err_q    <= 1'b1;
        end
      end
      if (sample) begin
        data_q <= nand_io_i;
        last_q <= (rem_q == NW'(1));
        rem_q  <= rem_q - 1'b1;
      end
      valid_q <= sample | (valid_q & ~dout_ready_i);
    end
  end

  assign in_wr         = (state_q == ST_WE_LO) || (state_q == ST_WE_HI);
  assign req_ready_o   = (state_q == ST_IDLE);
  assign nand_ce_no    = (state_q == ST_IDLE);
  assign nand_we_no    = (state_q != ST_WE_LO);
  assign nand_re_no    = (state_q != ST_RE_LO);
  assign nand_cle_o    = in_wr & beat.cle;
  assign nand_ale_o    = in_wr & beat.ale;
  assign nand_io_o     = in_wr ? beat.data : 8'h00;
  assign nand_io_oe_o  = in_wr;
  assign dout_valid_o  = valid_q;
  assign dout_data_o   = data_q;
  assign dout_last_o   = last_q;
  assign err_timeout_o = err_q;
endmodule

// File: rtl/nand_page_reader_chk.sv
module nand_page_reader_chk #(
  parameter int WE_LO_CYC = 2,
  parameter int RE_LO_CYC = 2
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_ready_o,
  input logic       dout_valid_o,
  input logic       dout_ready_i,
  input logic [7:0] dout_data_o,
  input logic       err_timeout_o,
  input logic       nand_ce_no,
  input logic       nand_cle_o,
  input logic       nand_ale_o,
  input logic       nand_we_no,
  input logic       nand_re_no,
  input logic       nand_rb_i
);
  logic [15:0] we_run, re_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_run <= '0;
      re_run <= '0;
    end else begin
      we_run <= nand_we_no ? 16'd0 : we_run + 16'd1;
      re_run <= nand_re_no ? 16'd0 : re_run + 16'd1;
    end
  end

  assert_strobe_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!nand_we_no && !nand_re_no));
  assert_latch_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nand_cle_o && nand_ale_o));
  assert_ready_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> nand_ce_no);
  assert_ce_active_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nand_we_no || !nand_re_no) |-> !nand_ce_no);
  assert_we_width_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nand_we_no) |-> (we_run == 16'(WE_LO_CYC)));
  assert_re_width_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nand_re_no) |-> (re_run == 16'(RE_LO_CYC)));
  assert_no_read_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nand_re_no |-> nand_rb_i);
  assert_hold_data_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dout_valid_o && !dout_ready_i) |=> (dout_valid_o && $stable(dout_data_o) && nand_re_no));
  assert_timeout_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_timeout_o) |-> nand_ce_no);
endmodule

bind nand_page_reader nand_page_reader_chk #(.WE_LO_CYC(WE_LO_CYC), .RE_LO_CYC(RE_LO_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_ready_o(req_ready_o), .dout_valid_o(dout_valid_o),
  .dout_ready_i(dout_ready_i), .dout_data_o(dout_data_o), .err_timeout_o(err_timeout_o),
  .nand_ce_no(nand_ce_no), .nand_cle_o(nand_cle_o), .nand_ale_o(nand_ale_o),
  .nand_we_no(nand_we_no), .nand_re_no(nand_re_no), .nand_rb_i(nand_rb_i)
);

// File: tb/nand_page_reader_test.sv
`timescale 1ns/1ps
module nand_page_reader_test;
  localparam int WE_LO = 2;
  localparam int RE_LO = 2;
  localparam int NVEC  = 7;
  // {jump, row[23:0], col[11:0], len[11:0]}
  localparam logic [48:0] VEC [NVEC] = '{
    {1'b0, 24'h012345, 12'd0,    12'd4},
    {1'b0, 24'h0A0B0C, 12'h123,  12'd3},
    {1'b1, 24'h000000, 12'h7FF,  12'd2},
    {1'b0, 24'h000001, 12'd2110, 12'd8},
    {1'b1, 24'h000000, 12'd2111, 12'd5},
    {1'b0, 24'h000003, 12'd2112, 12'd4},
    {1'b1, 24'h000000, 12'd5,    12'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_valid = 1'b0, req_jump = 1'b0, dout_ready = 1'b1;
  logic [23:0] req_row = '0;
  logic [11:0] req_col = '0, req_len = '0;
  logic        req_ready, dout_valid, dout_last, err_tmo;
  logic [7:0]  dout_data, io_o, io_in;
  logic        ce_n, cle, ale, we_n, re_n, io_oe, rb;

  nand_page_reader #(.WE_LO_CYC(WE_LO), .RE_LO_CYC(RE_LO)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_jump_i(req_jump), .req_row_i(req_row), .req_col_i(req_col), .req_len_i(req_len),
    .dout_valid_o(dout_valid), .dout_ready_i(dout_ready), .dout_data_o(dout_data),
    .dout_last_o(dout_last), .err_timeout_o(err_tmo), .nand_ce_no(ce_n), .nand_cle_o(cle),
    .nand_ale_o(ale), .nand_we_no(we_n), .nand_re_no(re_n), .nand_io_o(io_o),
    .nand_io_oe_o(io_oe), .nand_io_i(io_in), .nand_rb_i(rb)
  );

  function automatic logic [7:0] pat(input logic [23:0] r, input logic [11:0] c);
    return r[7:0] ^ r[15:8] ^ c[7:0] ^ {4'h0, c[11:8]} ^ 8'hA5;
  endfunction

  // ---------------- device model ----------------
  int          busy_cyc = 40;
  logic [9:0]  log_b [256];
  int          log_n, re_falls, we_bad, re_bad, busy_left, ac, we_run, re_run;
  logic [7:0]  ab [5];
  logic [23:0] m_row;
  logic [11:0] m_col;
  logic        we_p, re_p;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      log_n <= 0; re_falls <= 0; we_bad <= 0; re_bad <= 0; busy_left <= 0; ac <= 0;
      we_run <= 0; re_run <= 0; we_p <= 1'b1; re_p <= 1'b1; rb <= 1'b1; io_in <= 8'h00;
      m_row <= '0; m_col <= '0;
    end else begin
      we_p <= we_n;
      re_p <= re_n;
      we_run <= we_n ? 0 : we_run + 1;
      re_run <= re_n ? 0 : re_run + 1;
      if (busy_left != 0) begin
        busy_left <= busy_left - 1;
        if (busy_left == 1) rb <= 1'b1;
      end
      if (!ce_n && !we_p && we_n) begin
        if (we_run != WE_LO) we_bad <= we_bad + 1;
        log_b[log_n & 255] <= {cle, ale, io_o};
        log_n <= log_n + 1;
        if (cle) begin
          case (io_o)
            8'h00, 8'h05: ac <= 0;
            8'h30: begin
              m_row <= {ab[4], ab[3], ab[2]};
              m_col <= {ab[1][3:0], ab[0]};
              busy_left <= busy_cyc;
              rb <= 1'b0;
              ac <= 0;
            end
            8'hE0: begin
              m_col <= {ab[1][3:0], ab[0]};
              ac <= 0;
            end
            default: ;
          endcase
        end else if (ale && ac < 5) begin
          ab[ac] <= io_o;
          ac <= ac + 1;
        end
      end
      if (!ce_n && re_p && !re_n) begin
        io_in <= pat(m_row, m_col);
        m_col <= m_col + 12'd1;
        re_falls <= re_falls + 1;
      end
      if (!re_p && re_n && re_run != RE_LO) re_bad <= re_bad + 1;
    end
  end

  // ---------------- output collector ----------------
  logic [7:0] got_d [256];
  logic       got_l [256];
  int         n_out;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) n_out <= 0;
    else if (dout_valid && dout_ready) begin
      got_d[n_out & 255] <= dout_data;
      got_l[n_out & 255] <= dout_last;
      n_out <= n_out + 1;
    end
  end

  // ---------------- checking ----------------
  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  initial begin
    #(10ns * 190000);
    $display("watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
    $finish;
  end

  logic        b_loaded = 1'b0;
  logic [23:0] b_row = '0;
  logic [9:0]  e_log [7];
  int          e_log_n, e_n, out_base, log_base, fall_base;
  logic [23:0] e_row;
  logic [11:0] e_col;
  logic        e_full, e_tmo;
  string       e_tag;

  task automatic start_req(input logic jmp, input logic [23:0] row, input logic [11:0] col,
                           input logic [11:0] len, input logic tmo);
    int avail;
    e_full = !(jmp && b_loaded);
    e_tmo  = tmo;
    e_col  = col;
    e_log_n = 0;
    if (e_full) begin
      e_tag = b_loaded ? "R3" : "R2";
      if (!b_loaded) begin e_log[e_log_n] = {2'b10, 8'h00}; e_log_n++; end
      e_log[e_log_n] = {2'b01, col[7:0]};         e_log_n++;
      e_log[e_log_n] = {2'b01, 4'h0, col[11:8]};  e_log_n++;
      e_log[e_log_n] = {2'b01, row[7:0]};         e_log_n++;
      e_log[e_log_n] = {2'b01, row[15:8]};        e_log_n++;
      e_log[e_log_n] = {2'b01, row[23:16]};       e_log_n++;
      e_log[e_log_n] = {2'b10, 8'h30};            e_log_n++;
      e_row = row;
    end else begin
      e_tag = "R7";
      e_log[0] = {2'b10, 8'h05};
      e_log[1] = {2'b01, col[7:0]};
      e_log[2] = {2'b01, 4'h0, col[11:8]};
      e_log[3] = {2'b10, 8'hE0};
      e_log_n = 4;
      e_row = b_row;
    end
    avail = (col < 12'd2112) ? 2112 - int'(col) : 0;
    e_n = tmo ? 0 : ((int'(len) < avail) ? int'(len) : avail);
    out_base = n_out; log_base = log_n; fall_base = re_falls;
    @(negedge clk);
    req_jump = jmp; req_row = row; req_col = col; req_len = len; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready && !ce_n, "R10", "busy after accept (ready,ce_n)", {req_ready, ce_n}, 0);
    chk(err_tmo == 1'b0, "R8", "error cleared on accept", err_tmo, 0);
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!(req_ready && !dout_valid));
  endtask

  task automatic check_req();
    int bad_log, bad_d, bad_l, got;
    bad_log = 0; bad_d = 0; bad_l = 0;
    if (log_n - log_base != e_log_n) bad_log = 1;
    else for (int i = 0; i < e_log_n; i++)
      if (log_b[(log_base + i) & 255] !== e_log[i]) bad_log++;
    chk(bad_log == 0, e_tag, "command/address bytes (mismatches or bad length)", bad_log, 0);
    got = n_out - out_base;
    chk(got == e_n, "R5", "byte count", got, e_n);
    chk(re_falls - fall_base == e_n, "R5", "read strobe pulses", re_falls - fall_base, e_n);
    for (int i = 0; i < e_n && i < got; i++) begin
      if (got_d[(out_base + i) & 255] !== pat(e_row, e_col + 12'(i))) bad_d++;
      if (got_l[(out_base + i) & 255] !== (i == e_n - 1)) bad_l++;
    end
    chk(bad_d == 0, (e_tag == "R7") ? "R7" : "R5", "data mismatches", bad_d, 0);
    chk(bad_l == 0, "R5", "last flag mismatches", bad_l, 0);
    chk(err_tmo == e_tmo, "R8", "timeout flag", err_tmo, e_tmo);
    if (e_full) begin
      b_loaded = !e_tmo;
      if (!e_tmo) b_row = e_row;
    end
  endtask

  initial begin
    logic [7:0] d0;
    int         f0, bad;
    repeat (3) @(negedge clk);
    chk(ce_n && we_n && re_n && !cle && !ale && !io_oe, "R1", "bus idle in reset",
        {ce_n, we_n, re_n, cle, ale, io_oe}, 6'b111000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !dout_valid && !err_tmo, "R1", "ready/valid/err after reset",
        {req_ready, dout_valid, err_tmo}, 3'b100);

    for (int v = 0; v < NVEC; v++) begin
      start_req(VEC[v][48], VEC[v][47:24], VEC[v][23:12], VEC[v][11:0], 1'b0);
      wait_done();
      check_req();
    end

    // R6: backpressure holds RE high and data stable
    dout_ready = 1'b0;
    start_req(1'b0, 24'h00ABCD, 12'd100, 12'd4, 1'b0);
    do @(negedge clk); while (!dout_valid);
    d0 = dout_data; f0 = re_falls; bad = 0;
    repeat (20) begin
      @(negedge clk);
      if (!re_n || !dout_valid || dout_data !== d0) bad++;
    end
    chk(bad == 0 && re_falls == f0, "R6", "stall cycles with RE low or data change", bad, 0);
    dout_ready = 1'b1;
    wait_done();
    check_req();

    // R8: ready/busy never returns
    busy_cyc = 100000;
    start_req(1'b0, 24'h000055, 12'd0, 12'd3, 1'b1);
    wait_done();
    check_req();

    // R7/R8: jump with no page loaded becomes a full read with 00h
    busy_cyc = 40;
    start_req(1'b1, 24'h000066, 12'd7, 12'd2, 1'b0);
    wait_done();
    check_req();

    chk(we_bad == 0 && re_bad == 0, "R9", "strobe low widths off", we_bad + re_bad, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule